// File: doc/BRIEF.md
# Reload Down-Counter Timer

A down-counting timer driven by a count-enable tick from the surrounding clock domain. Software loads a start value into a reload register, then sets the enable and trigger bits of a control word; the timer copies the reload value into its counter and steps it down by one on each cycle in which the tick input is high. When the counter passes from zero to all-ones, an underflow has occurred. The timer latches a sticky underflow flag and raises an interrupt request if interrupts are enabled.

Two behaviours follow an underflow. In one-shot mode the counter stops and waits for a new trigger. In reload mode it takes the reload value again and keeps counting. The timer output pin gives a single pulse, whose active level can be selected, while a one-shot count runs. In reload mode the pin toggles on every underflow, starting from a selectable level. Only the software-trigger mode (mode field zero) starts the timer. A small register port with an address, write strobe, write data and combinational read data gives access to the control word, the reload value and the live count.

Top module: `reload_timer`

## Requirements
- R1: After reset, the control word, the reload value and the counter read as zero, and both `irq` and `tout` are low.
- R2: The control word is at address 0, with enable at bit 0, trigger at bit 1, reload select at bit 2, interrupt enable at bit 3, underflow flag at bit 4, output level at bit 5 and mode at bits 8:6. The reload value is at address 1 and the counter (read only) at address 2. A control write with both enable and trigger set, and an effective mode of 0, copies the reload value into the counter on that edge.
- R3: A running, enabled counter decrements by one on each clock edge at which `tick` is high. A step from 0 yields 16'hFFFF and sets the underflow flag.
- R4: `irq` is high exactly when both the underflow flag and interrupt enable are set.
- R5: With reload select 0, an underflow stops the counter at 16'hFFFF. Later ticks leave it there until the next trigger.
- R6: In one-shot mode `tout` equals the inverse of the output level bit while counting, and equals the level bit when idle.
- R7: With reload select 1, an underflow loads the reload value and counting continues without a trigger.
- R8: In reload mode `tout` starts at the output level bit when the timer is triggered and inverts on every underflow.
- R9: While enable is 0, ticks do not change the counter, and a trigger written together with enable 0 has no effect.
- R10: The trigger bit always reads 0. Writing 0 to the underflow flag clears it; writing 1 leaves it unchanged.
- R11: A trigger written while the counter is running reloads the counter from the reload value.
- R12: The mode field updates only on a write made while enable is 0. A trigger is ignored unless the mode is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable; one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Underflow interrupt request |
| tout | output | 1 | Timer output pin |

## Verification
The bench targets the counter's boundary steps: a zero reload, which underflows on the first tick, and counts that end one tick before the underflow, on it, and after it. A one-shot timer that kept running would show a wrapped value below 16'hFFFF, and a reload timer that stopped would hold 16'hFFFF. It checks that the toggle begins from the selected level, since an inverted start would flip every reading after that point. It also checks that the underflow flag ignores a written 1, that a trigger sent with enable low or with a nonzero mode does nothing, and that the mode field is locked while the timer is enabled. A design that got any of these wrong would restart or clear state it should have kept.

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq,
  output logic         tout
);
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_RLD = 2'd1;
  localparam logic [1:0] A_CNT = 2'd2;

  logic         en, rsel, ien, uf, lvl, run, tog;
  logic [2:0]   mode;
  logic [W-1:0] rld, cnt;

  wire       ctl_wr = wr_en && (addr == A_CTL);
  wire [2:0] mode_nx = (ctl_wr && !en) ? wdata[8:6] : mode;
  wire       start = ctl_wr && wdata[0] && wdata[1] && (mode_nx == 3'b000);
  wire       stop  = ctl_wr && !wdata[0];
  wire       step  = run && en && tick && !start && !stop;
  wire       uflow = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; rsel <= 1'b0; ien <= 1'b0; uf <= 1'b0;
      lvl <= 1'b0; run <= 1'b0; tog <= 1'b0; mode <= 3'b000;
      rld <= '0; cnt <= '0;
    end else begin
      if (ctl_wr) begin
        en   <= wdata[0];
        rsel <= wdata[2];
        ien  <= wdata[3];
        lvl  <= wdata[5];
        mode <= mode_nx;
        if (!wdata[4]) uf <= 1'b0;
      end
      if (wr_en && addr == A_RLD) rld <= wdata;
      if (uflow) uf <= 1'b1;

      if (start) begin
        cnt <= rld;
        run <= 1'b1;
        tog <= 1'b0;
      end else if (stop) begin
        run <= 1'b0;
      end else if (uflow) begin
        if (rsel) begin
          cnt <= rld;
          tog <= ~tog;
        end else begin
          cnt <= '1;
          run <= 1'b0;
        end
      end else if (step) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign irq  = uf && ien;
  assign tout = lvl ^ (rsel ? tog : run);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTL:   rdata[8:0] = {mode, lvl, uf, ien, rsel, 1'b0, en};
      A_RLD:   rdata = rld;
      A_CNT:   rdata = cnt;
      default: rdata = '0;
    endcase
  end

  p_uf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf) |-> ($past(cnt) == '0 && $past(run) && $past(tick)));

  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !rsel) |=> (!run && cnt == '1));

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && rsel && !(wr_en && addr == A_RLD)) |=> (run && cnt == $past(rld)));

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && rsel && !ctl_wr) |=> (tout != $past(tout)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ctl_wr) |=> $stable(cnt));

  p_mode_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(mode));
endmodule

// File: tb/test_reload_timer.sv
module test_reload_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, tout;

  int checks = 0;
  int errors = 0;
  logic [15:0] v;

  reload_timer i_reload_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tout(tout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {reload, ticks, expected count, expected flag}, one-shot runs
  localparam logic [48:0] VEC [8] = '{
    {16'd5,      16'd3,  16'd2,      1'b0},
    {16'd5,      16'd5,  16'd0,      1'b0},
    {16'd5,      16'd6,  16'hFFFF,   1'b1},
    {16'd5,      16'd9,  16'hFFFF,   1'b1},
    {16'd0,      16'd1,  16'hFFFF,   1'b1},
    {16'd0,      16'd0,  16'd0,      1'b0},
    {16'd100,    16'd40, 16'd60,     1'b0},
    {16'hFFFF,   16'd2,  16'hFFFD,   1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); chk(v == 16'h0, "R1 ctrl", v, 16'h0);
    rd(2'd1, v); chk(v == 16'h0, "R1 reload", v, 16'h0);
    rd(2'd2, v); chk(v == 16'h0, "R1 count", v, 16'h0);
    chk(irq == 0 && tout == 0, "R1 pins", {irq, tout}, 16'h0);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] r, n, ec;
      logic eu;
      {r, n, ec, eu} = VEC[i];
      wr(2'd1, r);
      wr(2'd0, 16'h0003);
      rd(2'd2, v); chk(v == r, "R2 load on trigger", v, r);
      ticks(int'(n));
      rd(2'd2, v); chk(v == ec, "R3/R5 count", v, ec);
      rd(2'd0, v); chk(v[4] == eu, "R3 underflow flag", {15'd0, v[4]}, {15'd0, eu});
      chk(v[1] == 1'b0, "R10 trigger reads 0", {15'd0, v[1]}, 16'd0);
      chk(tout == (n <= r), "R6 one-shot pulse", {15'd0, tout}, {15'd0, (n <= r)});
      chk(irq == 1'b0, "R4 no irq when disabled", {15'd0, irq}, 16'd0);
    end

    // R5 restart after stop
    wr(2'd1, 16'd4);
    wr(2'd0, 16'h0003);
    ticks(5);
    wr(2'd0, 16'h0011);
    rd(2'd2, v); chk(v == 16'hFFFF, "R5 stopped", v, 16'hFFFF);
    wr(2'd0, 16'h0013);
    ticks(1);
    rd(2'd2, v); chk(v == 16'd3, "R5 retrigger", v, 16'd3);

    // R6 active-low pulse
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0023);
    chk(tout == 1'b0, "R6 low while running", {15'd0, tout}, 16'd0);
    ticks(3);
    chk(tout == 1'b1, "R6 idle at level", {15'd0, tout}, 16'd1);

    // R4 irq
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h000B);
    ticks(1);
    chk(irq == 1'b0, "R4 irq before underflow", {15'd0, irq}, 16'd0);
    ticks(1);
    chk(irq == 1'b1, "R4 irq on underflow", {15'd0, irq}, 16'd1);
    // R10 writing 1 to flag keeps it
    wr(2'd0, 16'h0019);
    chk(irq == 1'b1, "R10 write 1 keeps flag", {15'd0, irq}, 16'd1);
    wr(2'd0, 16'h0009);
    chk(irq == 1'b0, "R10 write 0 clears flag", {15'd0, irq}, 16'd0);
    wr(2'd0, 16'h0019);
    rd(2'd0, v); chk(v[4] == 1'b0, "R10 write 1 does not set", {15'd0, v[4]}, 16'd0);

    // R7 R8 reload mode, level 0
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0007);
    chk(tout == 1'b0, "R8 starts at level 0", {15'd0, tout}, 16'd0);
    ticks(3);
    rd(2'd2, v); chk(v == 16'd2, "R7 reloaded", v, 16'd2);
    chk(tout == 1'b1, "R8 first toggle", {15'd0, tout}, 16'd1);
    ticks(3);
    rd(2'd2, v); chk(v == 16'd2, "R7 continues", v, 16'd2);
    chk(tout == 1'b0, "R8 second toggle", {15'd0, tout}, 16'd0);
    // R8 level 1
    wr(2'd0, 16'h0027);
    chk(tout == 1'b1, "R8 starts at level 1", {15'd0, tout}, 16'd1);
    ticks(3);
    chk(tout == 1'b0, "R8 toggle from level 1", {15'd0, tout}, 16'd0);

    // R11 retrigger while running
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0003);
    ticks(4);
    wr(2'd0, 16'h0003);
    rd(2'd2, v); chk(v == 16'd10, "R11 retrigger reloads", v, 16'd10);

    // R9 disabled hold
    ticks(2);
    wr(2'd0, 16'h0000);
    ticks(3);
    rd(2'd2, v); chk(v == 16'd8, "R9 hold when disabled", v, 16'd8);
    wr(2'd0, 16'h0002);
    rd(2'd2, v); chk(v == 16'd8, "R9 trigger ignored", v, 16'd8);

    // R12 mode gating
    wr(2'd0, 16'h0043);
    rd(2'd2, v); chk(v == 16'd8, "R12 nonzero mode blocks trigger", v, 16'd8);
    wr(2'd0, 16'h0003);
    rd(2'd0, v); chk(v[8:6] == 3'b001, "R12 mode locked while enabled", {13'd0, v[8:6]}, 16'd1);
    rd(2'd2, v); chk(v == 16'd8, "R12 trigger still blocked", v, 16'd8);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0003);
    rd(2'd2, v); chk(v == 16'd10, "R12 mode 0 allows trigger", v, 16'd10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule